// File: doc/BRIEF.md
# Bit-plane frame logic processor

This block combines two binary image planes with one of the sixteen two-input Boolean functions and writes the result to a chosen destination plane. A plane is a square or rectangular field of one-bit pixels packed eight to a byte; at the default size of 256 x 256 pixels it fills 8 KB. One byte-wide function unit serves the whole plane. It takes one source byte per cycle and, as each byte completes, writes one destination byte.

Software loads a command in one cycle. The command holds the operand pairing, the source and destination selection, the 4-bit function code and an X/Y translation. An arm pulse grants permission. The block then waits for the next frame-start pulse, raises a bus request, waits for the grant and sweeps the plane row by row. When the destination is a memory block, the result lands at translated coordinates. The coordinates wrap inside the block, and an X offset that is not a multiple of 8 is handled by merging adjacent result bytes. A scan address for the display refresh runs without a break, whatever the transfer engine is doing. All memories are synchronous byte RAMs whose read data appears one cycle after the address.

Top module: `plane_logic_engine`

## Requirements
- R1: While reset is held low, bus_req, done, disp_we and blk_we are all 0.
- R2: An arm pulse in the idle state latches every cmd_* input. bus_req rises in the cycle after the first frame_start that follows the arm cycle. A frame_start in the same cycle as arm does not count. Without an arm, frame_start never raises bus_req.
- R3: No write enable is asserted before bus_gnt is seen, and none is asserted without bus_gnt.
- R4: Each result bit equals cmd_fn[{a,b}], where a is operand A's bit and b is operand B's bit at the same position. Operand B is always the display plane. Pixel x of a row lies in byte x/8 of that row, at bit x mod 8. The byte address is row * (IMG_W/8) + x/8.
- R5: cmd_pair selects operand A. Code 0 takes memory block cmd_src_blk. Code 1 takes the live edge-detector plane. Codes 2 and 3 take the display plane, so the display is combined with itself.
- R6: With cmd_to_disp = 1, the result is written only to the display plane. With cmd_to_disp = 0, it is written only to block cmd_dst_blk. Every other plane is left unchanged.
- R7: With a block destination, the destination pixel (x, y) gets the result pixel ((x - dx) mod IMG_W, (y - dy) mod IMG_H). This holds for every dx, including values that are not multiples of 8. The source block must differ from the destination block when the offset is nonzero.
- R8: With the display as destination, cmd_dx and cmd_dy have no effect, and the result lands at its own coordinates.
- R9: Each run writes every destination byte exactly once, which is IMG_H * IMG_W/8 writes, and never more than one write per cycle.
- R10: done is a one-cycle pulse. It is observed IMG_H*(IMG_W/8+1)+2 cycles after the cycle in which bus_gnt is first presented, and bus_req is already low in that cycle.
- R11: disp_scan_addr is 0 in the cycle after frame_start and otherwise advances by one each cycle, wrapping at the plane size. It does this regardless of any transfer.
- R12: An arm pulse while a run is pending or active is ignored. It neither changes the command in use nor causes a further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_arm | input | 1 | Permission pulse; latches the command |
| cmd_pair | input | 2 | Operand A select: 0 block, 1 edge, 2/3 display |
| cmd_src_blk | input | BB | Source memory block index |
| cmd_to_disp | input | 1 | 1: result to display, 0: result to a block |
| cmd_dst_blk | input | BB | Destination memory block index |
| cmd_fn | input | 4 | Truth table of the function, indexed {a,b} |
| cmd_dx | input | XB | X translation for block destinations |
| cmd_dy | input | RB | Y translation for block destinations |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| bus_req | output | 1 | Bus request, held through the run |
| bus_gnt | input | 1 | Bus grant |
| done | output | 1 | One-cycle pulse after the last write |
| disp_raddr | output | PB | Display read address for the transfer |
| disp_rdata | input | 8 | Display read data, one cycle after the address |
| disp_we | output | 1 | Display write enable |
| disp_waddr | output | PB | Display write address |
| disp_wdata | output | 8 | Display write data |
| disp_scan_addr | output | PB | Free-running display refresh address |
| blk_raddr | output | BB+PB | Memory block read address {block, byte} |
| blk_rdata | input | 8 | Memory block read data |
| blk_we | output | 1 | Memory block write enable |
| blk_waddr | output | BB+PB | Memory block write address {block, byte} |
| blk_wdata | output | 8 | Memory block write data |
| edge_raddr | output | PB | Edge-detector plane read address |
| edge_rdata | input | 8 | Edge-detector plane read data |

## Verification
A wrong latched offset or bit shift does not stay hidden. At the end of the very run in which it occurs, it shows as misplaced bytes spread over the whole destination plane. A corrupted row or column counter changes both the number of write strobes and the cycle on which done appears, so a comparison of the two against the plane geometry exposes it within one run. A stale carry byte between rows damages only the first byte of each destination row, and a per-byte comparison across many offsets catches it.

// File: rtl/ple_pkg.sv
package ple_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ARMED = 3'd1,
        S_REQ   = 3'd2,
        S_RUN   = 3'd3,
        S_FLUSH = 3'd4
    } ple_state_e;
endpackage

// File: rtl/ple_fn_unit.sv
module ple_fn_unit (
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic [3:0] fn,
    output logic [7:0] r
);
    // Each bit looks up the truth table with index {a,b} (R4)
    for (genvar k = 0; k < 8; k++) begin : g_bit
        assign r[k] = fn[{a[k], b[k]}];
    end
endmodule

// File: rtl/ple_merge.sv
module ple_merge (
    input  logic [7:0] cur,
    input  logic [7:0] prev,
    input  logic [2:0] sh,
    output logic [7:0] out
);
    logic [15:0] pair_w;
    always_comb begin
        pair_w = {cur, prev} >> sh;
        out    = pair_w[7:0];
    end
endmodule

// File: rtl/ple_scan.sv
module ple_scan #(
    parameter int PB = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [PB-1:0] scan_addr
);
    logic [PB-1:0] scan_d, scan_q;

    always_comb begin
        scan_d = frame_start ? '0 : scan_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign scan_addr = scan_q;

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> scan_addr == $past(scan_addr) + 1'b1); // R11
    AST_SCAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> scan_addr == '0); // R11
endmodule

// File: rtl/plane_logic_engine.sv
module plane_logic_engine #(
    parameter int IMG_W = 256,
    parameter int IMG_H = 256,
    parameter int NBLK  = 4,
    localparam int COLS = IMG_W / 8,
    localparam int CB   = $clog2(COLS),
    localparam int RB   = $clog2(IMG_H),
    localparam int XB   = $clog2(IMG_W),
    localparam int PB   = RB + CB,
    localparam int BB   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_arm,
    input  logic [1:0]       cmd_pair,
    input  logic [BB-1:0]    cmd_src_blk,
    input  logic             cmd_to_disp,
    input  logic [BB-1:0]    cmd_dst_blk,
    input  logic [3:0]       cmd_fn,
    input  logic [XB-1:0]    cmd_dx,
    input  logic [RB-1:0]    cmd_dy,
    input  logic             frame_start,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             done,
    output logic [PB-1:0]    disp_raddr,
    input  logic [7:0]       disp_rdata,
    output logic             disp_we,
    output logic [PB-1:0]    disp_waddr,
    output logic [7:0]       disp_wdata,
    output logic [PB-1:0]    disp_scan_addr,
    output logic [BB+PB-1:0] blk_raddr,
    input  logic [7:0]       blk_rdata,
    output logic             blk_we,
    output logic [BB+PB-1:0] blk_waddr,
    output logic [7:0]       blk_wdata,
    output logic [PB-1:0]    edge_raddr,
    input  logic [7:0]       edge_rdata
);
    import ple_pkg::*;

    localparam logic [CB:0]   COLS_L   = (CB+1)'(COLS);
    localparam logic [RB-1:0] ROW_LAST = RB'(IMG_H - 1);

    typedef struct packed {
        ple_state_e    st;
        logic [1:0]    pair;
        logic [BB-1:0] sblk;
        logic          to_disp;
        logic [BB-1:0] dblk;
        logic [3:0]    fn;
        logic [CB-1:0] qb;     // byte part of the negated X offset
        logic [2:0]    sh;     // bit part of the negated X offset
        logic [RB-1:0] dy;
        logic [RB-1:0] row;    // destination row being read for
        logic [CB:0]   col;    // read step within the row, 0..COLS
        logic          v1;     // read data valid this cycle
        logic [RB-1:0] row1;
        logic [CB:0]   col1;
        logic [7:0]    prev;   // previous result byte of the row
        logic          done;
    } ctl_t;

    ctl_t d, q;

    logic [XB-1:0] neg_dx;
    logic [RB-1:0] src_row;
    logic [CB-1:0] src_col;
    logic [CB-1:0] dst_col;
    logic [7:0]    op_a;
    logic [7:0]    res;
    logic [7:0]    merged;
    logic          wr;

    // Translation is dropped for a display destination (R8)
    always_comb begin
        neg_dx = cmd_to_disp ? '0 : ({XB{1'b0}} - cmd_dx);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.v1   = 1'b0;
        if (q.v1) d.prev = res;
        case (q.st)
            S_IDLE: begin
                if (cmd_arm) begin
                    d.st      = S_ARMED;
                    d.pair    = cmd_pair;
                    d.sblk    = cmd_src_blk;
                    d.to_disp = cmd_to_disp;
                    d.dblk    = cmd_dst_blk;
                    d.fn      = cmd_fn;
                    d.qb      = neg_dx[XB-1:3];
                    d.sh      = neg_dx[2:0];
                    d.dy      = cmd_to_disp ? '0 : cmd_dy;
                end
            end
            S_ARMED: begin
                if (frame_start) d.st = S_REQ;
            end
            S_REQ: begin
                if (bus_gnt) begin
                    d.st  = S_RUN;
                    d.row = '0;
                    d.col = '0;
                end
            end
            S_RUN: begin
                d.v1   = 1'b1;
                d.row1 = q.row;
                d.col1 = q.col;
                if (q.col == COLS_L) begin
                    d.col = '0;
                    if (q.row == ROW_LAST) d.st = S_FLUSH;
                    else                   d.row = q.row + 1'b1;
                end else begin
                    d.col = q.col + 1'b1;
                end
            end
            S_FLUSH: begin
                d.st   = S_IDLE;
                d.done = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Source address: destination coordinates minus the offset, wrapped
    always_comb begin
        src_row = q.row - q.dy;
        src_col = q.qb + q.col[CB-1:0];
        dst_col = q.col1[CB-1:0] - 1'b1;
        case (q.pair)
            2'd0:    op_a = blk_rdata;
            2'd1:    op_a = edge_rdata;
            default: op_a = disp_rdata;
        endcase
    end

    ple_fn_unit u_fn (
        .a  (op_a),
        .b  (disp_rdata),
        .fn (q.fn),
        .r  (res)
    );

    ple_merge u_merge (
        .cur  (res),
        .prev (q.prev),
        .sh   (q.sh),
        .out  (merged)
    );

    ple_scan #(.PB(PB)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .scan_addr   (disp_scan_addr)
    );

    assign wr         = q.v1 && (q.col1 != '0);
    assign disp_raddr = {src_row, src_col};
    assign edge_raddr = {src_row, src_col};
    assign blk_raddr  = {q.sblk, src_row, src_col};
    assign disp_we    = wr && q.to_disp;
    assign blk_we     = wr && !q.to_disp;
    assign disp_waddr = {q.row1, dst_col};
    assign blk_waddr  = {q.dblk, q.row1, dst_col};
    assign disp_wdata = merged;
    assign blk_wdata  = merged;
    assign bus_req    = (q.st == S_REQ) || (q.st == S_RUN) || (q.st == S_FLUSH);
    assign done       = q.done;

    AST_REQ_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(frame_start)); // R2
    AST_WRITE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_we || blk_we) |-> bus_gnt); // R3
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_we, blk_we})); // R6
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(disp_we || blk_we)); // R9
endmodule

// File: tb/sim_plane_logic_engine.sv
module sim_plane_logic_engine;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 32;
    localparam int H    = 8;
    localparam int NB   = 4;
    localparam int COLS = W / 8;
    localparam int NBY  = W * H / 8;
    localparam int PB   = 5;
    localparam int BB   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_arm = 1'b0;
    logic [1:0] cmd_pair = '0;
    logic [BB-1:0] cmd_src_blk = '0;
    logic cmd_to_disp = 1'b0;
    logic [BB-1:0] cmd_dst_blk = '0;
    logic [3:0] cmd_fn = '0;
    logic [4:0] cmd_dx = '0;
    logic [2:0] cmd_dy = '0;
    logic frame_start = 1'b0;
    logic bus_req;
    logic bus_gnt = 1'b0;
    logic done;
    logic [PB-1:0] disp_raddr, disp_waddr, disp_scan_addr, edge_raddr;
    logic [7:0] disp_rdata, disp_wdata, blk_rdata, blk_wdata, edge_rdata;
    logic disp_we, blk_we;
    logic [BB+PB-1:0] blk_raddr, blk_waddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    plane_logic_engine #(.IMG_W(W), .IMG_H(H), .NBLK(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_pair(cmd_pair),
        .cmd_src_blk(cmd_src_blk), .cmd_to_disp(cmd_to_disp), .cmd_dst_blk(cmd_dst_blk),
        .cmd_fn(cmd_fn), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy), .frame_start(frame_start),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .done(done),
        .disp_raddr(disp_raddr), .disp_rdata(disp_rdata), .disp_we(disp_we),
        .disp_waddr(disp_waddr), .disp_wdata(disp_wdata), .disp_scan_addr(disp_scan_addr),
        .blk_raddr(blk_raddr), .blk_rdata(blk_rdata), .blk_we(blk_we),
        .blk_waddr(blk_waddr), .blk_wdata(blk_wdata),
        .edge_raddr(edge_raddr), .edge_rdata(edge_rdata)
    );

    // Memory models: synchronous read, one-cycle latency
    logic [7:0] dmem [NBY];
    logic [7:0] bmem [NB][NBY];
    logic [7:0] emem [NBY];
    logic reseed = 1'b0;
    int   seed_v = 0;

    always @(posedge clk) begin
        disp_rdata <= dmem[disp_raddr];
        blk_rdata  <= bmem[blk_raddr[BB+PB-1:PB]][blk_raddr[PB-1:0]];
        edge_rdata <= emem[edge_raddr];
        if (reseed) begin
            for (int i = 0; i < NBY; i++) begin
                dmem[i] <= 8'(i * 37 + seed_v * 53 + 11);
                emem[i] <= 8'(i * 151 + seed_v * 17 + 99);
                for (int b = 0; b < NB; b++)
                    bmem[b][i] <= 8'(i * 73 + b * 29 + seed_v * 7 + 5);
            end
        end else begin
            if (disp_we) dmem[disp_waddr] <= disp_wdata;
            if (blk_we)  bmem[blk_waddr[BB+PB-1:PB]][blk_waddr[PB-1:0]] <= blk_wdata;
        end
    end

    int nchk = 0;
    int nfail = 0;
    int wcnt = 0;
    int bad_w = 0;
    int cyc = 0;
    int run_no = 0;

    always @(negedge clk) begin
        if (disp_we || blk_we) begin
            wcnt = wcnt + (disp_we ? 1 : 0) + (blk_we ? 1 : 0);
            if (!bus_gnt) bad_w = bad_w + 1;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic [7:0] sd [NBY];
    logic [7:0] sb [NB][NBY];
    logic [7:0] se [NBY];

    function automatic int pbit(input int which, input int x, input int y);
        int idx;
        idx = y * COLS + x / 8;
        if (which < NB)      return int'(sb[which][idx][x % 8]);
        else if (which == NB) return int'(sd[idx][x % 8]);
        else                  return int'(se[idx][x % 8]);
    endfunction

    task automatic run_op(input int pair, input int sblk, input int todisp, input int dblk,
                          input int fn, input int dx, input int dy, input int mode,
                          input int gdelay, input string tag);
        int n, ex, ey, asrc, okp;
        run_no = run_no + 1;
        @(negedge clk);
        seed_v = run_no;
        reseed = 1'b1;
        @(negedge clk);
        reseed = 1'b0;
        for (int i = 0; i < NBY; i++) begin
            sd[i] = dmem[i];
            se[i] = emem[i];
            for (int b = 0; b < NB; b++) sb[b][i] = bmem[b][i];
        end
        cmd_pair = 2'(pair); cmd_src_blk = BB'(sblk); cmd_to_disp = todisp[0];
        cmd_dst_blk = BB'(dblk); cmd_fn = 4'(fn); cmd_dx = 5'(dx); cmd_dy = 3'(dy);
        cmd_arm = 1'b1;
        if (mode == 1) frame_start = 1'b1;
        @(negedge clk);
        cmd_arm = 1'b0;
        frame_start = 1'b0;
        if (mode == 1) chk(bus_req == 1'b0, "R2 same-cycle frame ignored", int'(bus_req), 0);
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R2 no request before frame", int'(bus_req), 0);
        wcnt = 0;
        bad_w = 0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(bus_req == 1'b1, "R2 request after frame", int'(bus_req), 1);
        repeat (gdelay) @(negedge clk);
        chk(wcnt == 0 && bus_req, "R3 no write before grant", wcnt, 0);
        bus_gnt = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
            if (mode == 2 && n == 10) begin
                cmd_fn = ~cmd_fn; cmd_dx = cmd_dx + 5'd3; cmd_arm = 1'b1;
            end
            if (mode == 2 && n == 11) cmd_arm = 1'b0;
        end while (!done && n < 400);
        chk(n == H * (COLS + 1) + 2, "R10 done timing", n, H * (COLS + 1) + 2);
        chk(bus_req == 1'b0, "R10 request dropped with done", int'(bus_req), 0);
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
        chk(wcnt == H * COLS, "R9 write count", wcnt, H * COLS);
        chk(bad_w == 0, "R3 writes only under grant", bad_w, 0);
        if (mode == 2) begin
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            @(negedge clk);
            chk(bus_req == 1'b0, "R12 arm during run ignored", int'(bus_req), 0);
        end
        ex = todisp ? 0 : dx;
        ey = todisp ? 0 : dy;
        asrc = (pair == 0) ? sblk : ((pair == 1) ? NB + 1 : NB);
        for (int y = 0; y < H; y++) begin
            for (int c = 0; c < COLS; c++) begin
                logic [7:0] expb, got;
                for (int k = 0; k < 8; k++) begin
                    int sx, sy, a, b;
                    sx = (c * 8 + k - ex + 2 * W) % W;
                    sy = (y - ey + 2 * H) % H;
                    a = pbit(asrc, sx, sy);
                    b = pbit(NB, sx, sy);
                    expb[k] = fn[a * 2 + b];
                end
                got = todisp ? dmem[y * COLS + c] : bmem[dblk][y * COLS + c];
                chk(got == expb, tag, int'(got), int'(expb));
            end
        end
        okp = 1;
        for (int i = 0; i < NBY; i++) begin
            if (!todisp && dmem[i] != sd[i]) okp = 0;
            if (emem[i] != se[i]) okp = 0;
            for (int b = 0; b < NB; b++)
                if ((todisp || b != dblk) && bmem[b][i] != sb[b][i]) okp = 0;
        end
        chk(okp == 1, "R6 other planes untouched", okp, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !done && !disp_we && !blk_we, "R1 reset outputs",
            int'({bus_req, done, disp_we, blk_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !done, "R1 idle after reset", int'({bus_req, done}), 0);

        // R11: scan restart and wrap, frame without arm gives no request (R2)
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(disp_scan_addr == '0, "R11 scan restart", int'(disp_scan_addr), 0);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            chk(int'(disp_scan_addr) == k % NBY, "R11 scan step", int'(disp_scan_addr), k % NBY);
        end
        chk(bus_req == 1'b0, "R2 frame without arm", int'(bus_req), 0);

        // R4 R5 R7: all functions, block with display, translated into another block
        for (int f = 0; f < 16; f++)
            run_op(0, f % NB, 0, (f + 1) % NB, f, (f * 5 + 3) % W, (f * 3 + 1) % H, 0, f % 3,
                   "R4 R7 block pair");
        // R5 R8: edge with display to display, offsets must be ignored
        for (int f = 0; f < 16; f++)
            run_op(1, 0, 1, 0, f, f + 1, 1 + f % 7, 0, 1, "R5 R8 edge pair");
        // R7: full X offset sweep with display self pairing into blocks
        for (int dx = 0; dx < W; dx++)
            run_op(2, 0, 0, dx % NB, 14, dx, (dx * 3) % H, 0, 0, "R7 offset sweep");
        // R5: code 3 behaves as display with itself
        run_op(3, 1, 1, 0, 6, 0, 0, 0, 2, "R5 pair code 3");
        run_op(3, 1, 0, 2, 9, 13, 5, 0, 0, "R5 pair code 3 to block");
        // R2: arm together with a frame start
        run_op(0, 2, 0, 3, 8, 9, 2, 1, 1, "R2 R4 same cycle arm");
        // R12: arm during an active run
        run_op(0, 3, 0, 1, 6, 11, 6, 2, 0, "R12 R4 arm mid run");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule